// File: doc/BRIEF.md
# Tracking Angle Counter with Output Hold

This block keeps a 16-bit binary angle that follows incremental tracking requests. Each request on the up or down input adds or removes one unit from a signed backlog. An internal stepping engine works through that backlog one least-significant step at a time. The angle is binary: the top bit is worth 180 degrees and each lower bit is worth half the one above it, so one step is about 0.0055 degrees. The count wraps around modulo 2^16.

A host reads the angle from a latched parallel output. When the latch takes a new value, a busy pulse marks the update. The pulse has a fixed width, and pulses are spaced so that the host can always tell two updates apart.

A hold input freezes the latch so the host can read a stable word. While the hold is applied, the internal angle keeps following requests. A hold that arrives inside a busy pulse does not cut the pulse short: it takes effect after the pulse and its spacing gap have run out. When the hold is released, the latch takes the internal angle. If that value differs from the frozen one, a new busy pulse is issued.

A built-in-test flag compares the internal angle with a supplied target angle. It rises when the wrapped distance between them exceeds a set tolerance.

The controller has four states:
- `ST_IDLE`: waiting for work.
- `ST_BUSY`: the busy pulse is being driven.
- `ST_GAP`: the enforced low time after a pulse.
- `ST_HOLD`: the latch is frozen.

Its transitions are:
- IDLE→BUSY: a step is taken and latched.
- IDLE→HOLD: the hold input is seen.
- BUSY→GAP: the pulse width has elapsed.
- GAP→IDLE: the spacing has elapsed.
- HOLD→BUSY: release with a changed angle.
- HOLD→IDLE: release with an unchanged angle.

Top module: `trk_angle_ctr`

## Requirements
- R1: The internal angle only ever changes by exactly +1 or −1 (mod 2^16) per clock. Stepping up from 0xFFFF gives 0x0000, and stepping down from 0x0000 gives 0xFFFF. Bit 15 of the word weighs 180 degrees.
- R2: Outside hold, each step loads the new angle into `angle_out` on the same clock edge on which `busy` rises. `angle_out` never changes without a rising `busy`.
- R3: `busy` stays high for exactly BUSY_CYC (default 4) cycles. After it falls, it stays low for at least GAP_CYC (default 6) cycles before it can rise again.
- R4: Requests that arrive while an update is in progress are kept as a signed backlog and applied one step per busy pulse. An up and a down request in the same cycle cancel, and no pulse results. Every request is eventually applied.
- R5: While `inhibit` is high and no pulse is in progress, `angle_out` is frozen and `busy` stays low. The internal angle still follows requests at one step per clock.
- R6: A hold raised while `busy` is high does not shorten the pulse and does not disturb the value that was just latched. The freeze applies from the end of that update onward.
- R7: On the first clock with `inhibit` low after a hold, `angle_out` takes the internal angle. A busy pulse marks this only if the value changed.
- R8: `bit_fail` becomes 1 one clock after the wrapped distance |target − angle| (taken on the shorter way round the circle) exceeds BIT_TOL (default 8). Otherwise it is 0.
- R9: After reset, `angle_out` is 0, `busy` is 0, `bit_fail` is 0 and the backlog is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_up | input | 1 | Request one step up (one per cycle high) |
| step_dn | input | 1 | Request one step down (one per cycle high) |
| target | input | 16 | Reference angle used only by the test flag |
| inhibit | input | 1 | Hold request that freezes `angle_out` |
| busy | output | 1 | Converter-busy pulse marking a latch update |
| angle_out | output | 16 | Latched angle seen by the host |
| bit_fail | output | 1 | Tracking-error flag |

## Verification
The bound checker watches several properties on every cycle:
- The internal angle moves by a single step at a time, including across the wrap.
- Every change of the latched word coincides with a rising busy edge.
- Each busy pulse has the configured width and is preceded by the required low time.
- The latch stays frozen and busy stays quiet while a hold that began outside a pulse is in force.

Some behaviours need the bench's scenarios instead:
- That queued requests arrive in order with the right values.
- That simultaneous up and down requests cancel.
- That the latch picks up steps taken during a hold on release, or stays silent when nothing changed.
- That the test flag switches exactly at the tolerance boundary on both sides of the wrap.

// File: rtl/trk_pkg.sv
package trk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_GAP  = 2'd2,
        ST_HOLD = 2'd3
    } trk_state_e;
endpackage

// File: rtl/trk_pending.sv
// Signed backlog of step requests, saturating at the symmetric limits.
module trk_pending #(
    parameter int PEND_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_up,
    input  logic req_dn,
    input  logic take,
    output logic has_work,
    output logic dir_up
);
    localparam int SUM_W = PEND_W + 2;
    localparam logic signed [SUM_W-1:0] ONE_W  = {{(SUM_W-1){1'b0}}, 1'b1};
    localparam logic signed [SUM_W-1:0] SAT_HI = {3'b000, {(PEND_W-1){1'b1}}};
    localparam logic signed [SUM_W-1:0] SAT_LO = {3'b111, {(PEND_W-2){1'b0}}, 1'b1};

    logic signed [PEND_W-1:0] cnt_q;
    logic signed [PEND_W-1:0] cnt_d;
    logic signed [SUM_W-1:0]  sum_w;

    assign has_work = (cnt_q != '0);
    assign dir_up   = ~cnt_q[PEND_W-1];

    always_comb begin
        sum_w = {{2{cnt_q[PEND_W-1]}}, cnt_q};
        if (req_up && !req_dn) sum_w = sum_w + ONE_W;
        if (req_dn && !req_up) sum_w = sum_w - ONE_W;
        if (take)              sum_w = dir_up ? (sum_w - ONE_W) : (sum_w + ONE_W);
        if (sum_w > SAT_HI)      cnt_d = SAT_HI[PEND_W-1:0];
        else if (sum_w < SAT_LO) cnt_d = SAT_LO[PEND_W-1:0];
        else                     cnt_d = sum_w[PEND_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/trk_bit_check.sv
// Registered tracking-error flag on the wrapped angle distance.
module trk_bit_check #(
    parameter int ANG_W   = 16,
    parameter int BIT_TOL = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ANG_W-1:0] angle,
    input  logic [ANG_W-1:0] target,
    output logic             fail
);
    localparam logic [ANG_W-1:0] TOL_W = ANG_W'(BIT_TOL);
    localparam logic [ANG_W-1:0] ONE_A = {{(ANG_W-1){1'b0}}, 1'b1};

    logic [ANG_W-1:0] diff;
    logic [ANG_W-1:0] mag;

    always_comb begin
        diff = target - angle;
        mag  = diff[ANG_W-1] ? (~diff + ONE_A) : diff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fail <= 1'b0;
        else        fail <= (mag > TOL_W);
    end
endmodule

// File: rtl/trk_angle_ctr.sv
// Tracking angle counter: one-step updates, busy pulse, host hold latch.
module trk_angle_ctr
    import trk_pkg::*;
#(
    parameter int ANG_W    = 16,
    parameter int BUSY_CYC = 4,
    parameter int GAP_CYC  = 6,
    parameter int PEND_W   = 8,
    parameter int BIT_TOL  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_up,
    input  logic             step_dn,
    input  logic [ANG_W-1:0] target,
    input  logic             inhibit,
    output logic             busy,
    output logic [ANG_W-1:0] angle_out,
    output logic             bit_fail
);
    localparam int CNT_MAX = (BUSY_CYC > GAP_CYC) ? BUSY_CYC : GAP_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] BUSY_LAST = CNT_W'(BUSY_CYC - 1);
    localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(GAP_CYC - 1);
    localparam logic [CNT_W-1:0] CNT_ONE   = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [ANG_W-1:0] ANG_ONE   = {{(ANG_W-1){1'b0}}, 1'b1};

    trk_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [ANG_W-1:0] ang_q, ang_step, out_q, out_d;
    logic             step_en, load_out;
    logic             has_work, dir_up;

    trk_pending #(.PEND_W(PEND_W)) u_pending (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_up   (step_up),
        .req_dn   (step_dn),
        .take     (step_en),
        .has_work (has_work),
        .dir_up   (dir_up)
    );

    trk_bit_check #(.ANG_W(ANG_W), .BIT_TOL(BIT_TOL)) u_bit (
        .clk    (clk),
        .rst_n  (rst_n),
        .angle  (ang_q),
        .target (target),
        .fail   (bit_fail)
    );

    assign ang_step = dir_up ? (ang_q + ANG_ONE) : (ang_q - ANG_ONE);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state and step/load decisions.
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        step_en  = 1'b0;
        load_out = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (inhibit) begin
                    state_d = ST_HOLD;
                end else if (has_work) begin
                    step_en  = 1'b1;
                    load_out = 1'b1;
                    state_d  = ST_BUSY;
                    cnt_d    = '0;
                end
            end
            ST_BUSY: begin
                if (cnt_q == BUSY_LAST) begin
                    state_d = ST_GAP;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CNT_ONE;
                end
            end
            ST_GAP: begin
                if (cnt_q == GAP_LAST) state_d = ST_IDLE;
                else                   cnt_d   = cnt_q + CNT_ONE;
            end
            ST_HOLD: begin
                if (!inhibit) begin
                    load_out = 1'b1;
                    cnt_d    = '0;
                    state_d  = (ang_q != out_q) ? ST_BUSY : ST_IDLE;
                end else if (has_work) begin
                    step_en = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Latch input: the fresh step in IDLE, the tracked angle on release.
    always_comb begin
        out_d = out_q;
        if (load_out) out_d = (state_q == ST_IDLE) ? ang_step : ang_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ang_q <= '0;
            out_q <= '0;
        end else begin
            if (step_en) ang_q <= ang_step;
            out_q <= out_d;
        end
    end

    // Outputs.
    always_comb begin
        busy      = (state_q == ST_BUSY);
        angle_out = out_q;
    end
endmodule

// File: rtl/trk_angle_ctr_chk.sv
// Property checker bound to trk_angle_ctr.
module trk_angle_ctr_chk #(
    parameter int ANG_W    = 16,
    parameter int BUSY_CYC = 4,
    parameter int GAP_CYC  = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             inhibit,
    input logic             busy,
    input logic [ANG_W-1:0] angle_out,
    input logic [ANG_W-1:0] ang_int
);
    localparam int RUN_W = $clog2(BUSY_CYC + 2) + 1;
    localparam int LOW_W = $clog2(GAP_CYC + 2) + 1;
    localparam logic [ANG_W-1:0] ONE_A = {{(ANG_W-1){1'b0}}, 1'b1};
    localparam logic [ANG_W-1:0] ALL_A = {ANG_W{1'b1}};
    localparam logic [LOW_W-1:0] LOW_SAT = LOW_W'(GAP_CYC);
    localparam logic [RUN_W-1:0] RUN_EXP = RUN_W'(BUSY_CYC);

    logic             past_ok;
    logic [RUN_W-1:0] run_q;
    logic [LOW_W-1:0] low_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
            run_q   <= '0;
            low_q   <= LOW_SAT;
        end else begin
            past_ok <= 1'b1;
            run_q   <= busy ? (run_q + 1'b1) : '0;
            low_q   <= busy ? '0 : ((low_q >= LOW_SAT) ? LOW_SAT : (low_q + 1'b1));
        end
    end

    p_one_lsb_r1: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && (ang_int != $past(ang_int)) |->
            ((ang_int - $past(ang_int)) == ONE_A) || ((ang_int - $past(ang_int)) == ALL_A));

    p_busy_lead_r2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && (angle_out != $past(angle_out)) |-> busy && !$past(busy));

    p_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $fell(busy) |-> (run_q == RUN_EXP));

    p_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $rose(busy) |-> (low_q >= LOW_SAT));

    p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(inhibit) && !$past(busy) |-> $stable(angle_out) && !busy);

    p_busy_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy && inhibit |=> $stable(angle_out));
endmodule

bind trk_angle_ctr trk_angle_ctr_chk #(
    .ANG_W    (ANG_W),
    .BUSY_CYC (BUSY_CYC),
    .GAP_CYC  (GAP_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .inhibit   (inhibit),
    .busy      (busy),
    .angle_out (angle_out),
    .ang_int   (ang_q)
);

// File: tb/trk_angle_ctr_bench.sv
`timescale 1ns/1ps
module trk_angle_ctr_bench;
    localparam int BUSY_CYC = 4;
    localparam int GAP_CYC  = 6;
    localparam int BIT_TOL  = 8;
    localparam int SPACE    = BUSY_CYC + GAP_CYC + 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_up = 1'b0;
    logic        step_dn = 1'b0;
    logic [15:0] target = 16'h0;
    logic        inhibit = 1'b0;
    logic        busy;
    logic [15:0] angle_out;
    logic        bit_fail;

    int pass_cnt = 0;
    int fail_cnt = 0;
    int pulse_cnt = 0;
    int run_len = 0;
    int low_len = 100;
    logic prev_busy = 1'b0;
    logic [15:0] mdl = 16'h0;
    logic [15:0] exp_q[$];

    always #2.5 clk = ~clk;

    trk_angle_ctr #(
        .ANG_W(16), .BUSY_CYC(BUSY_CYC), .GAP_CYC(GAP_CYC), .PEND_W(8), .BIT_TOL(BIT_TOL)
    ) u_trk_angle_ctr (
        .clk(clk), .rst_n(rst_n), .step_up(step_up), .step_dn(step_dn),
        .target(target), .inhibit(inhibit), .busy(busy),
        .angle_out(angle_out), .bit_fail(bit_fail)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        if (ok) pass_cnt++;
        else begin
            fail_cnt++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: n requests in consecutive cycles, each queuing its expected word.
    task automatic drive_steps(input bit up, input int n, input bit expect_pulse);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            step_up = up;
            step_dn = !up;
            mdl = up ? mdl + 16'h1 : mdl - 16'h1;
            if (expect_pulse) exp_q.push_back(mdl);
        end
        @(negedge clk);
        step_up = 1'b0;
        step_dn = 1'b0;
    endtask

    // Monitor: pops one expected word at every rising busy, checks pulse shape.
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && !prev_busy) begin
                pulse_cnt++;
                chk(low_len >= GAP_CYC, "R3", "busy spacing", low_len, GAP_CYC);
                if (exp_q.size() == 0)
                    chk(1'b0, "R2", "unexpected busy pulse, word", angle_out, 32'hFFFFFFFF);
                else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    chk(angle_out == e, "R2", "word at busy rise", angle_out, e);
                end
            end
            if (!busy && prev_busy)
                chk(run_len == BUSY_CYC, "R3", "busy width", run_len, BUSY_CYC);
            run_len = busy ? run_len + 1 : 0;
            low_len = busy ? 0 : low_len + 1;
            prev_busy = busy;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        fail_cnt++;
        $display("FAIL watchdog: actual=timeout expected=done");
        summary();
        $finish;
    end

    initial begin
        int p0;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        // R9 reset state
        chk(angle_out == 16'h0, "R9", "angle_out after reset", angle_out, 0);
        chk(busy == 1'b0, "R9", "busy after reset", busy, 0);
        chk(bit_fail == 1'b0, "R9", "bit_fail after reset", bit_fail, 0);

        // R2 single step
        drive_steps(1'b1, 1, 1'b1);
        tick(SPACE + 3);
        chk(angle_out == 16'h1, "R2", "after single up", angle_out, 1);

        // R4 burst queued and applied one per pulse
        drive_steps(1'b1, 3, 1'b1);
        tick(3 * SPACE + 5);
        chk(angle_out == 16'h4, "R4", "after burst of three", angle_out, 4);

        // R1 downward wrap then upward wrap
        drive_steps(1'b0, 5, 1'b1);
        tick(5 * SPACE + 5);
        chk(angle_out == 16'hFFFF, "R1", "down through zero", angle_out, 16'hFFFF);
        drive_steps(1'b1, 1, 1'b1);
        tick(SPACE + 3);
        chk(angle_out == 16'h0000, "R1", "up through FFFF", angle_out, 0);

        // R4 simultaneous up and down cancel
        p0 = pulse_cnt;
        @(negedge clk); step_up = 1'b1; step_dn = 1'b1;
        @(negedge clk); step_up = 1'b0; step_dn = 1'b0;
        tick(SPACE + 5);
        chk(pulse_cnt == p0, "R4", "pulses after cancelling pair", pulse_cnt, p0);

        // R5 hold: latch frozen, no pulses, internal angle follows
        @(negedge clk); inhibit = 1'b1;
        tick(2);
        p0 = pulse_cnt;
        drive_steps(1'b1, 3, 1'b0);
        tick(SPACE);
        chk(angle_out == 16'h0, "R5", "frozen word during hold", angle_out, 0);
        chk(pulse_cnt == p0, "R5", "pulses during hold", pulse_cnt, p0);
        // R7 release with a changed angle
        exp_q.push_back(mdl);
        @(negedge clk); inhibit = 1'b0;
        tick(SPACE + 3);
        chk(pulse_cnt == p0 + 1, "R7", "pulses after release", pulse_cnt, p0 + 1);
        chk(angle_out == 16'h3, "R7", "word after release", angle_out, 3);

        // R6 hold raised inside a busy pulse
        drive_steps(1'b1, 1, 1'b1);
        while (!busy) @(negedge clk);
        inhibit = 1'b1;
        tick(BUSY_CYC + GAP_CYC + 4);
        chk(angle_out == 16'h4, "R6", "word kept after busy with hold", angle_out, 4);
        chk(busy == 1'b0, "R6", "busy ended under hold", busy, 0);
        p0 = pulse_cnt;
        drive_steps(1'b0, 1, 1'b0);
        tick(4);
        chk(angle_out == 16'h4, "R5", "frozen while stepping down", angle_out, 4);
        exp_q.push_back(mdl);
        @(negedge clk); inhibit = 1'b0;
        tick(SPACE + 3);
        chk(angle_out == 16'h3, "R7", "release picks up held step", angle_out, 3);

        // R7 release with no change gives no pulse
        @(negedge clk); inhibit = 1'b1;
        tick(5);
        p0 = pulse_cnt;
        @(negedge clk); inhibit = 1'b0;
        tick(SPACE + 3);
        chk(pulse_cnt == p0, "R7", "pulses after unchanged release", pulse_cnt, p0);

        // R8 tolerance boundary on both sides, angle is 3
        @(negedge clk); target = 16'd11; tick(2);
        chk(bit_fail == 1'b0, "R8", "distance +8", bit_fail, 0);
        @(negedge clk); target = 16'd12; tick(2);
        chk(bit_fail == 1'b1, "R8", "distance +9", bit_fail, 1);
        @(negedge clk); target = 16'hFFFB; tick(2);
        chk(bit_fail == 1'b0, "R8", "distance -8 across wrap", bit_fail, 0);
        @(negedge clk); target = 16'hFFFA; tick(2);
        chk(bit_fail == 1'b1, "R8", "distance -9 across wrap", bit_fail, 1);
        @(negedge clk); target = 16'h8003; tick(2);
        chk(bit_fail == 1'b1, "R8", "half-turn distance", bit_fail, 1);
        @(negedge clk); target = 16'd3; tick(2);
        chk(bit_fail == 1'b0, "R8", "on target", bit_fail, 0);

        chk(exp_q.size() == 0, "R4", "queued updates left over", exp_q.size(), 0);
        summary();
        $finish;
    end
endmodule